// File: doc/BRIEF.md
# GPIO Interrupt Router

This block turns any of a wide bank of GPIO lines into one of 32 interrupt channels. Each channel has a select byte. The select byte holds an enable bit and the index of the GPIO line to watch. Each channel also has a 2-bit condition field that chooses rising edge, falling edge, high level or low level. When the enabled condition is seen, the channel latches a pending bit. While that bit is set and the channel is enabled, the channel drives an active-high level request toward the parent interrupt controller. Software clears a pending bit by writing zero to it in the status register.

Each channel is a two-state machine. In CH_IDLE no pending bit is held. The transition IDLE_TO_PEND fires when the enabled condition is seen in a cycle. In CH_PEND the pending bit is held. The transition PEND_TO_IDLE fires when a zero is written to the channel's status bit in a cycle in which the condition is not seen. In every other case the state holds. Edge history is sampled every cycle whether or not the channel is enabled. The register port is a single-cycle write strobe with a combinational read-back of the addressed word.

Top module: `gpio_irq_router`

## Requirements
- R1: Channel n owns byte n mod 4 of the select word at offset 0x30 + 4*(n/4), in bits 8*(n mod 4)+7 down to 8*(n mod 4). In that byte, bit 7 enables the channel and bits 6:0 give the GPIO index. Written words read back unchanged.
- R2: Channel n owns a 2-bit condition field at bit 2*(n mod 16). Channels 0 to 15 use offset 0x24 and channels 16 to 31 use offset 0x28. Written words read back unchanged. Other offsets read zero.
- R3: Condition code 0 (rising) sets the pending bit on the clock edge that follows a cycle in which the selected line is 1 and was 0 in the cycle before.
- R4: Condition code 1 (falling) sets the pending bit only on a 1-to-0 change of the selected line. A 0-to-1 change does not set it.
- R5: Condition codes 2 (level high) and 3 (level low) set the pending bit on every clock edge at which the line holds that level.
- R6: The status word at offset 0x20 shows bit n = pending bit of channel n. Writing 0 to a bit clears it. Writing 1 leaves it unchanged. A pending bit holds until it is cleared.
- R7: When a set condition and a clear of the same bit fall in one cycle, the bit is left set.
- R8: irq_req[n] is high exactly when channel n is pending and enabled. Disabling a pending channel drops its request but keeps its pending bit.
- R9: A disabled channel never sets its pending bit. Line changes made while it is disabled are not seen as an edge when it is enabled.
- R10: A GPIO index at or above the bus width selects a constant 0 input.
- R11: Reset clears all select, condition and status bits and holds every request low.
- R12: The sequence of select with enable off, new condition, status clear, then enable raises no pending bit when the new line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed word |
| gpio_in | input | GPIO_W (100) | GPIO input bus |
| irq_req | output | NUM_CH (32) | Active-high level requests, one per channel |

## Verification
A register write takes effect on the clock edge where it is strobed, and the read-back is visible in the same cycle, right after that edge. A condition is judged from the line value and the control registers as they stand in the cycle before an edge. The pending bit and the request both change on that edge, so they are due one edge after the stimulus. The bench drives inputs on falling edges. It samples the read data and the requests one clock later on the next falling edge, so every check falls half a cycle after the rising edge that should have produced the result. Table rows hold their stimulus for a second cycle. The expected values were worked out to stay the same through that extra edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int SRC_W    = 7;
    localparam int EN_BIT   = 7;

    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h20;
    localparam logic [ADDR_W-1:0] COND_OFS = 8'h24;
    localparam logic [ADDR_W-1:0] SEL_OFS  = 8'h30;

    typedef enum logic [1:0] {
        COND_RISE = 2'd0,
        COND_FALL = 2'd1,
        COND_HIGH = 2'd2,
        COND_LOW  = 2'd3
    } cond_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
    parameter int NUM_CH = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_i,
    input  logic [gpio_irq_pkg::ADDR_W-1:0]      addr_i,
    input  logic [gpio_irq_pkg::DATA_W-1:0]      wdata_i,
    input  logic [NUM_CH-1:0]                    pend_i,
    output logic [gpio_irq_pkg::DATA_W-1:0]      rdata_o,
    output logic [7:0]                           sel_o  [NUM_CH],
    output logic [1:0]                           cond_o [NUM_CH],
    output logic [NUM_CH-1:0]                    clr_o
);
    import gpio_irq_pkg::*;

    localparam int CH_PER_SEL  = 4;
    localparam int CH_PER_COND = 16;

    logic [7:0] sel_q  [NUM_CH];
    logic [1:0] cond_q [NUM_CH];

    function automatic logic [ADDR_W-1:0] sel_addr(input int n);
        return ADDR_W'(int'(SEL_OFS) + 4 * (n / CH_PER_SEL));
    endfunction

    function automatic logic [ADDR_W-1:0] cond_addr(input int n);
        return ADDR_W'(int'(COND_OFS) + 4 * (n / CH_PER_COND));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_CH; n++) begin
                sel_q[n]  <= '0;
                cond_q[n] <= '0;
            end
        end else if (wr_i) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr_i == sel_addr(n))
                    sel_q[n] <= wdata_i[8*(n % CH_PER_SEL) +: 8];
                if (addr_i == cond_addr(n))
                    cond_q[n] <= wdata_i[2*(n % CH_PER_COND) +: 2];
            end
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            clr_o[n]  = wr_i && (addr_i == STAT_OFS) && !wdata_i[n];
            sel_o[n]  = sel_q[n];
            cond_o[n] = cond_q[n];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == STAT_OFS)
            rdata_o[NUM_CH-1:0] = pend_i;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr_i == sel_addr(n))
                rdata_o[8*(n % CH_PER_SEL) +: 8] = sel_q[n];
            if (addr_i == cond_addr(n))
                rdata_o[2*(n % CH_PER_COND) +: 2] = cond_q[n];
        end
    end

    // R11: configuration is clear in the first cycle after reset
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_q[0] == '0 && cond_q[0] == '0 && pend_i == '0));

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan #(
    parameter int GPIO_W = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GPIO_W-1:0]       gpio_i,
    input  logic [7:0]              sel_i,
    input  gpio_irq_pkg::cond_e     cond_i,
    input  logic                    clr_i,
    output logic                    pend_o,
    output logic                    irq_o
);
    import gpio_irq_pkg::*;

    ch_state_e             state_q, state_d;
    logic [SRC_W-1:0]      idx;
    logic                  en;
    logic                  cur;
    logic                  prev_q;
    logic                  hit;

    assign idx = sel_i[SRC_W-1:0];
    assign en  = sel_i[EN_BIT];

    always_comb begin
        cur = 1'b0;
        if (int'(idx) < GPIO_W)
            cur = gpio_i[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    always_comb begin
        unique case (cond_i)
            COND_RISE: hit = en && cur && !prev_q;
            COND_FALL: hit = en && !cur && prev_q;
            COND_HIGH: hit = en && cur;
            COND_LOW:  hit = en && !cur;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (hit)             state_d = CH_PEND;
            CH_PEND: if (clr_i && !hit)   state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == CH_PEND);
        irq_o  = pend_o && en;
    end

    // R7: a detected condition always leaves the channel pending
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_o);
    // R6: a clear with no new condition empties the channel
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i && !hit) |=> !pend_o);
    // R6: pending holds until cleared
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
    // R9: a disabled idle channel stays idle
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pend_o) |=> !pend_o);

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
    parameter int NUM_CH = 32,
    parameter int GPIO_W = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [GPIO_W-1:0]   gpio_in,
    output logic [NUM_CH-1:0]   irq_req
);
    import gpio_irq_pkg::*;

    logic [7:0]        sel  [NUM_CH];
    logic [1:0]        cond [NUM_CH];
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] pend;

    gpio_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .pend_i  (pend),
        .rdata_o (reg_rdata),
        .sel_o   (sel),
        .cond_o  (cond),
        .clr_o   (clr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        gpio_irq_chan #(.GPIO_W(GPIO_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .gpio_i (gpio_in),
            .sel_i  (sel[n]),
            .cond_i (cond_e'(cond[n])),
            .clr_i  (clr[n]),
            .pend_o (pend[n]),
            .irq_o  (irq_req[n])
        );
    end

endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int GW  = 100;
    localparam int NVEC = 17;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [GW-1:0]  gpio = '0;
    logic [NCH-1:0] irq_req;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_router u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gpio_in   (gpio),
        .irq_req   (irq_req)
    );

    // {wr, addr, wdata, gpio[10], expected pending ch5, expected irq ch5}
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b1, 8'h34, 32'h0000_8A00, 1'b0, 1'b0, 1'b0}, // R1 enable ch5 on line 10
        {1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b1}, // R3 rising edge
        {1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b1}, // R6 held
        {1'b1, 8'h20, 32'hFFFF_FFDF, 1'b1, 1'b0, 1'b0}, // R6 write-zero clear
        {1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0}, // R6 ones no effect
        {1'b1, 8'h24, 32'h0000_0400, 1'b0, 1'b0, 1'b0}, // R4 select falling
        {1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R4 rise ignored
        {1'b0, 8'h00, 32'h0000_0000, 1'b0, 1'b1, 1'b1}, // R4 falling edge
        {1'b1, 8'h20, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R6 clear
        {1'b1, 8'h24, 32'h0000_0800, 1'b0, 1'b0, 1'b0}, // R5 level high
        {1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b1}, // R5 high sets
        {1'b1, 8'h20, 32'h0000_0000, 1'b1, 1'b1, 1'b1}, // R7 set beats clear
        {1'b1, 8'h20, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R6 clear once idle
        {1'b1, 8'h24, 32'h0000_0C00, 1'b0, 1'b0, 1'b0}, // R5 level low (set by 2nd cycle)
        {1'b0, 8'h00, 32'h0000_0000, 1'b0, 1'b1, 1'b1}, // R5 low sets
        {1'b1, 8'h34, 32'h0000_0A00, 1'b0, 1'b1, 1'b0}, // R8 disable drops request
        {1'b1, 8'h20, 32'h0000_0000, 1'b0, 1'b0, 1'b0}  // R9 disabled stays clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd_check("R11 status", 8'h20, 32'h0);
        rd_check("R11 cond", 8'h24, 32'h0);
        rd_check("R11 select", 8'h30, 32'h0);
        check("R11 irq", irq_req, 32'h0);

        // table walk on channel 5, line 10
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            reg_wr    = VEC[i][43];
            reg_addr  = VEC[i][42:35];
            reg_wdata = VEC[i][34:3];
            gpio[10]  = VEC[i][2];
            @(negedge clk);
            reg_wr   = 1'b0;
            reg_addr = 8'h20;
            #1;
            check($sformatf("R3-R9 row %0d pending", i), {31'b0, reg_rdata[5]}, {31'b0, VEC[i][1]});
            check($sformatf("R8 row %0d irq", i), {31'b0, irq_req[5]}, {31'b0, VEC[i][0]});
        end
        gpio = '0;

        // R1 / R2 readback
        wr(8'h3C, 32'h1234_5678);
        rd_check("R1 select readback", 8'h3C, 32'h1234_5678);
        wr(8'h28, 32'hA5A5_A5A5);
        rd_check("R2 cond readback", 8'h28, 32'hA5A5_A5A5);
        rd_check("R2 unmapped", 8'h2C, 32'h0);
        wr(8'h3C, 32'h0);
        wr(8'h28, 32'h0);

        // R10 out-of-range index selects constant 0
        wr(8'h30, 32'h0000_00F8);
        @(negedge clk); gpio = '1;
        idle(2);
        gpio = '0;
        idle(2);
        rd_check("R10 out of range", 8'h20, 32'h0);
        check("R10 irq", irq_req, 32'h0);

        // R9 no false edge on enable (ch1, line 3, rising)
        wr(8'h30, 32'h0000_0300);
        @(negedge clk); gpio[3] = 1'b1;
        idle(3);
        wr(8'h30, 32'h0000_8300);
        idle(2);
        rd_check("R9 no false edge", 8'h20, 32'h0);
        @(negedge clk); gpio[3] = 1'b0;
        idle(2);
        @(negedge clk); gpio[3] = 1'b1;
        idle(1);
        rd_check("R3 live after enable", 8'h20, 32'h0000_0002);
        wr(8'h20, 32'hFFFF_FFFD);

        // R12 reprogram sequence: move ch1 to line 4, falling
        wr(8'h30, 32'h0000_0400);
        wr(8'h24, 32'h0000_0C04);
        wr(8'h20, 32'hFFFF_FFFD);
        wr(8'h30, 32'h0000_8400);
        idle(2);
        rd_check("R12 no spurious", 8'h20, 32'h0);
        check("R12 irq", irq_req, 32'h0);
        @(negedge clk); gpio[4] = 1'b1;
        idle(1);
        @(negedge clk); gpio[4] = 1'b0;
        idle(1);
        rd_check("R4 new source falling", 8'h20, 32'h0000_0002);
        check("R8 irq ch1", irq_req, 32'h0000_0002);

        // R11 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R11 irq after reset", irq_req, 32'h0);
        rd_check("R11 status after reset", 8'h20, 32'h0);
        rd_check("R11 cond after reset", 8'h24, 32'h0);
        rd_check("R11 select after reset", 8'h30, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule